// File: doc/BRIEF.md
# PWM Output Fault Guard

This block sits between a PWM timer and its port pins. It holds the two 8-bit vectors that decide how the pins behave: the output-override-enable vector and the pin direction vector. When an enabled fault event arrives, it forces one of these vectors to all zeros without any processor involvement. Clearing the override vector hands every pin back to its plain port setting. Clearing the direction vector turns every pin into a tri-stated input. The fault also sets a fault flag and raises an error interrupt request when that request is enabled.

Recovery always happens on a timer UPDATE strobe. Two recovery policies are available. In latched mode, software must clear the flag before the UPDATE brings the pins back. In cycle-by-cycle mode, the first UPDATE after the fault condition ends is enough. On recovery, the cleared vector is reloaded in one of two ways. With pattern mode on, it takes the pattern buffer. Otherwise, each pin pair whose dead-time channel is enabled is set and the other pairs stay cleared.

The control settings can be frozen with a lock bit. Once set, the lock holds until reset.

Top module: `pwm_fault_guard`

## Requirements
- R1: The fault condition is the OR over the event channels whose mask bit is set, gated by the protection enable. An event on a masked-off channel, or any event while protection is off, leaves the outputs and the flag unchanged.
- R2: With action code 0 (clear overrides), an event sampled at clock edge k makes `ov_o` all zeros after edge k+1. `dir_o` is not changed by the fault.
- R3: With action code 1 (clear directions), an event sampled at edge k makes `dir_o` all zeros after edge k+1. `ov_o` is not changed by the fault.
- R4: The fault flag rises after edge k+1 for an event sampled at edge k. `err_irq_o` is the flag gated by the interrupt enable, registered on the same edge as the flag.
- R5: In latched mode (`cfg_cyc_mode`=0), the pins stay in the fault state while the flag is set, even across UPDATE strobes. After the condition has ended and the flag has been cleared, the first UPDATE restores them.
- R6: In cycle-by-cycle mode (`cfg_cyc_mode`=1), the first UPDATE seen after the condition has ended restores the pins. The flag may still be set.
- R7: The restore value is `pat_buf` when `pat_mode`=1. Otherwise, bits 2k and 2k+1 equal `dti_en[k]` for k=0..3. Only the vector the action cleared is reloaded.
- R8: A flag-clear strobe has no effect while the registered fault condition is active or while an enabled event is present in that same cycle. Otherwise it clears the flag on the next edge.
- R9: After a control write with `cfg_lock`=1, every further control write is ignored until reset.
- R10: While in the fault state, writes to the cleared vector are dropped. Writes to the other vector take effect on the next edge, as they do outside a fault.
- R11: After a synchronous reset, `ov_o`, `dir_o`, the flag and `err_irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_EVT | Event channel inputs |
| cfg_wr | input | 1 | Control write strobe |
| cfg_evt_en | input | N_EVT | Fault mask per channel (write data) |
| cfg_prot_en | input | 1 | Protection enable (write data) |
| cfg_act | input | 1 | Action: 0 clear overrides, 1 clear directions |
| cfg_cyc_mode | input | 1 | 1 cycle-by-cycle recovery, 0 latched |
| cfg_irq_en | input | 1 | Error interrupt enable (write data) |
| cfg_lock | input | 1 | Lock bit (write data) |
| upd_i | input | 1 | Timer UPDATE strobe |
| flag_clr_i | input | 1 | Software flag-clear strobe |
| ov_wr | input | 1 | Override vector write strobe |
| ov_wdata | input | OUT_W | Override vector write data |
| dir_wr | input | 1 | Direction vector write strobe |
| dir_wdata | input | OUT_W | Direction vector write data |
| pat_mode | input | 1 | Pattern generation mode |
| pat_buf | input | OUT_W | Pattern buffer value |
| dti_en | input | OUT_W/2 | Dead-time channel enables |
| ov_o | output | OUT_W | Output-override-enable vector |
| dir_o | output | OUT_W | Pin direction vector |
| fault_flag_o | output | 1 | Fault detection flag |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The bench builds the block with four event channels and an 8-bit output, which gives four dead-time pairs. The small channel count makes random events land often on both masked and unmasked channels, so the mask OR of R1 is covered densely. With eight output bits, every pair-expanded restore value and arbitrary pattern values can be checked exactly. Frequent random UPDATE and flag-clear strobes reach both recovery policies, as well as the race between a flag clear and a new event.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic {
    ACT_CLR_OVR = 1'b0,
    ACT_CLR_DIR = 1'b1
  } fg_act_e;

  typedef struct packed {
    logic    prot_en;
    fg_act_e act;
    logic    cyc_mode;
    logic    irq_en;
  } fg_ctl_t;

endpackage

// File: rtl/fg_cfg_regs.sv
module fg_cfg_regs
  import fg_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  fg_ctl_t          ctl_i,
  input  logic             lock_i,
  output logic [N_EVT-1:0] evt_en_q,
  output fg_ctl_t          ctl_q,
  output logic             lock_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_en_q <= '0;
      ctl_q    <= '0;
      lock_q   <= 1'b0;
    end else if (wr_i && !lock_q) begin
      evt_en_q <= evt_en_i;
      ctl_q    <= ctl_i;
      lock_q   <= lock_i;
    end
  end

endmodule

// File: rtl/fg_detect.sv
module fg_detect #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] evt_en,
  input  logic             prot_en,
  output logic             raw_o,
  output logic             cond_q
);

  assign raw_o = prot_en & (|(evt_i & evt_en));

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= raw_o;
  end

endmodule

// File: rtl/fg_fsm.sv
module fg_fsm
  import fg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    raw_i,
  input  logic    cond_i,
  input  logic    upd_i,
  input  logic    flag_clr_i,
  input  logic    cyc_mode,
  input  logic    irq_en,
  input  fg_act_e act_cfg,
  output logic    fault_st_q,
  output logic    flag_q,
  output logic    irq_q,
  output fg_act_e act_q,
  output fg_act_e act_eff,
  output logic    recover_o
);

  logic flag_d;

  assign recover_o = fault_st_q & ~cond_i & upd_i & (cyc_mode | ~flag_q);
  assign act_eff   = fault_st_q ? act_q : act_cfg;

  always_comb begin
    flag_d = flag_q;
    if (cond_i)                  flag_d = 1'b1;
    else if (flag_clr_i && !raw_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_st_q <= 1'b0;
      flag_q     <= 1'b0;
      irq_q      <= 1'b0;
      act_q      <= ACT_CLR_OVR;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
      if (cond_i) begin
        fault_st_q <= 1'b1;
        if (!fault_st_q) act_q <= act_cfg;
      end else if (recover_o) begin
        fault_st_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fg_outregs.sv
module fg_outregs
  import fg_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ov_wr,
  input  logic [OUT_W-1:0] ov_wdata,
  input  logic             dir_wr,
  input  logic [OUT_W-1:0] dir_wdata,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             recover_i,
  input  fg_act_e          act_i,
  input  logic             pat_mode,
  input  logic [OUT_W-1:0] pat_buf,
  input  logic [OUT_W/2-1:0] dti_en,
  output logic [OUT_W-1:0] ov_q,
  output logic [OUT_W-1:0] dir_q
);

  localparam int PAIRS = OUT_W / 2;

  logic [OUT_W-1:0] pair_v;
  logic [OUT_W-1:0] rest_v;
  logic             ov_tgt;
  logic             dir_tgt;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pair_v[2*k]   = dti_en[k];
    assign pair_v[2*k+1] = dti_en[k];
  end

  assign rest_v  = pat_mode ? pat_buf : pair_v;
  assign ov_tgt  = (act_i == ACT_CLR_OVR);
  assign dir_tgt = (act_i == ACT_CLR_DIR);

  always_ff @(posedge clk) begin
    if (rst)                       ov_q <= '0;
    else if (ov_tgt && clr_i)      ov_q <= '0;
    else if (ov_tgt && recover_i)  ov_q <= rest_v;
    else if (ov_tgt && hold_i)     ov_q <= ov_q;
    else if (ov_wr)                ov_q <= ov_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                       dir_q <= '0;
    else if (dir_tgt && clr_i)     dir_q <= '0;
    else if (dir_tgt && recover_i) dir_q <= rest_v;
    else if (dir_tgt && hold_i)    dir_q <= dir_q;
    else if (dir_wr)               dir_q <= dir_wdata;
  end

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import fg_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int OUT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_EVT-1:0]   evt_i,
  input  logic               cfg_wr,
  input  logic [N_EVT-1:0]   cfg_evt_en,
  input  logic               cfg_prot_en,
  input  logic               cfg_act,
  input  logic               cfg_cyc_mode,
  input  logic               cfg_irq_en,
  input  logic               cfg_lock,
  input  logic               upd_i,
  input  logic               flag_clr_i,
  input  logic               ov_wr,
  input  logic [OUT_W-1:0]   ov_wdata,
  input  logic               dir_wr,
  input  logic [OUT_W-1:0]   dir_wdata,
  input  logic               pat_mode,
  input  logic [OUT_W-1:0]   pat_buf,
  input  logic [OUT_W/2-1:0] dti_en,
  output logic [OUT_W-1:0]   ov_o,
  output logic [OUT_W-1:0]   dir_o,
  output logic               fault_flag_o,
  output logic               err_irq_o
);

  fg_ctl_t          ctl_in;
  fg_ctl_t          ctl_q;
  logic [N_EVT-1:0] evt_en_q;
  logic             lock_q;
  logic             raw_hit;
  logic             cond_q;
  logic             fault_st;
  logic             recover;
  fg_act_e          act_q;
  fg_act_e          act_eff;

  always_comb begin
    ctl_in.prot_en  = cfg_prot_en;
    ctl_in.act      = fg_act_e'(cfg_act);
    ctl_in.cyc_mode = cfg_cyc_mode;
    ctl_in.irq_en   = cfg_irq_en;
  end

  fg_cfg_regs #(.N_EVT(N_EVT)) u_cfg (
    .clk(clk), .rst(rst), .wr_i(cfg_wr), .evt_en_i(cfg_evt_en),
    .ctl_i(ctl_in), .lock_i(cfg_lock),
    .evt_en_q(evt_en_q), .ctl_q(ctl_q), .lock_q(lock_q)
  );

  fg_detect #(.N_EVT(N_EVT)) u_det (
    .clk(clk), .rst(rst), .evt_i(evt_i), .evt_en(evt_en_q),
    .prot_en(ctl_q.prot_en), .raw_o(raw_hit), .cond_q(cond_q)
  );

  fg_fsm u_fsm (
    .clk(clk), .rst(rst), .raw_i(raw_hit), .cond_i(cond_q),
    .upd_i(upd_i), .flag_clr_i(flag_clr_i), .cyc_mode(ctl_q.cyc_mode),
    .irq_en(ctl_q.irq_en), .act_cfg(ctl_q.act),
    .fault_st_q(fault_st), .flag_q(fault_flag_o), .irq_q(err_irq_o),
    .act_q(act_q), .act_eff(act_eff), .recover_o(recover)
  );

  fg_outregs #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .ov_wr(ov_wr), .ov_wdata(ov_wdata),
    .dir_wr(dir_wr), .dir_wdata(dir_wdata), .clr_i(cond_q),
    .hold_i(fault_st), .recover_i(recover), .act_i(act_eff),
    .pat_mode(pat_mode), .pat_buf(pat_buf), .dti_en(dti_en),
    .ov_q(ov_o), .dir_q(dir_o)
  );

endmodule

// File: rtl/fg_checker.sv
module fg_checker
  import fg_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             raw_hit,
  input logic             cond_q,
  input logic             fault_st,
  input logic             flag,
  input logic             irq,
  input fg_act_e          act_q,
  input logic             cyc_mode,
  input logic             upd,
  input logic             lock_q,
  input logic [N_EVT-1:0] evt_en_q,
  input fg_ctl_t          ctl_q,
  input logic [OUT_W-1:0] ov_o,
  input logic [OUT_W-1:0] dir_o
);

  AST_FLAG_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    cond_q |=> flag);                                                   // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);                                                      // R4
  AST_OVR_SAFE: assert property (@(posedge clk) disable iff (rst)
    (fault_st && act_q == ACT_CLR_OVR) |-> (ov_o == '0));               // R2
  AST_DIR_SAFE: assert property (@(posedge clk) disable iff (rst)
    (fault_st && act_q == ACT_CLR_DIR) |-> (dir_o == '0));              // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fault_st && !cyc_mode && flag) |=> fault_st);                      // R5
  AST_EXIT_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    (fault_st && !upd) |=> fault_st);                                   // R6
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (flag && (cond_q || raw_hit)) |=> flag);                            // R8
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(evt_en_q) && $stable(ctl_q) && lock_q));        // R9

endmodule

bind pwm_fault_guard fg_checker #(.N_EVT(N_EVT), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .raw_hit(raw_hit), .cond_q(cond_q),
  .fault_st(fault_st), .flag(fault_flag_o), .irq(err_irq_o),
  .act_q(act_q), .cyc_mode(ctl_q.cyc_mode), .upd(upd_i),
  .lock_q(lock_q), .evt_en_q(evt_en_q), .ctl_q(ctl_q),
  .ov_o(ov_o), .dir_o(dir_o)
);

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;

  localparam int N_EVT = 4;
  localparam int OUT_W = 8;
  localparam int PAIRS = OUT_W / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_EVT-1:0] evt_i = '0;
  logic cfg_wr = 0, cfg_prot_en = 0, cfg_act = 0, cfg_cyc_mode = 0;
  logic cfg_irq_en = 0, cfg_lock = 0;
  logic [N_EVT-1:0] cfg_evt_en = '0;
  logic upd_i = 0, flag_clr_i = 0, ov_wr = 0, dir_wr = 0, pat_mode = 0;
  logic [OUT_W-1:0] ov_wdata = '0, dir_wdata = '0, pat_buf = '0;
  logic [PAIRS-1:0] dti_en = '0;
  logic [OUT_W-1:0] ov_o, dir_o;
  logic fault_flag_o, err_irq_o;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  pwm_fault_guard #(.N_EVT(N_EVT), .OUT_W(OUT_W)) u0 (.*);

  // reference state derived from the requirements
  logic m_prot, m_actc, m_cc, m_irqen, m_lock, m_cond, m_st, m_flag, m_irq, m_act;
  logic [N_EVT-1:0] m_en;
  logic [OUT_W-1:0] m_ov, m_dir;

  function automatic logic [OUT_W-1:0] restore_val(logic pm, logic [OUT_W-1:0] pb,
                                                   logic [PAIRS-1:0] d);
    logic [OUT_W-1:0] r;
    for (int k = 0; k < PAIRS; k++) begin
      r[2*k]   = d[k];
      r[2*k+1] = d[k];
    end
    return pm ? pb : r;
  endfunction

  always @(posedge clk) begin
    logic raw, rec, nflag, eact, nst;
    logic [OUT_W-1:0] rv, nov, ndir;
    if (rst) begin
      {m_prot, m_actc, m_cc, m_irqen, m_lock, m_cond, m_st, m_flag, m_irq, m_act} = '0;
      m_en = '0; m_ov = '0; m_dir = '0;
    end else begin
      raw   = m_prot && ((evt_i & m_en) != '0);
      eact  = m_st ? m_act : m_actc;
      rv    = restore_val(pat_mode, pat_buf, dti_en);
      rec   = m_st && !m_cond && upd_i && (m_cc || !m_flag);
      nflag = m_cond ? 1'b1 : ((flag_clr_i && !raw) ? 1'b0 : m_flag);
      nst   = m_cond ? 1'b1 : (rec ? 1'b0 : m_st);
      nov = m_ov; ndir = m_dir;
      if (eact == 1'b0 && m_cond) nov = '0;
      else if (eact == 1'b0 && rec) nov = rv;
      else if (eact == 1'b0 && m_st) nov = m_ov;
      else if (ov_wr) nov = ov_wdata;
      if (eact == 1'b1 && m_cond) ndir = '0;
      else if (eact == 1'b1 && rec) ndir = rv;
      else if (eact == 1'b1 && m_st) ndir = m_dir;
      else if (dir_wr) ndir = dir_wdata;
      if (m_cond && !m_st) m_act = m_actc;
      m_irq = nflag && m_irqen;
      m_flag = nflag; m_st = nst; m_ov = nov; m_dir = ndir; m_cond = raw;
      if (cfg_wr && !m_lock) begin
        m_en = cfg_evt_en; m_prot = cfg_prot_en; m_actc = cfg_act;
        m_cc = cfg_cyc_mode; m_irqen = cfg_irq_en; m_lock = cfg_lock;
      end
    end
  end

  task automatic check_val(string tag, string what, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_model(string tag);
    check_val(tag, "ov_o",  ov_o,  m_ov);
    check_val(tag, "dir_o", dir_o, m_dir);
    check_val(tag, "flag",  {7'd0, fault_flag_o}, {7'd0, m_flag});
    check_val(tag, "irq",   {7'd0, err_irq_o},    {7'd0, m_irq});
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0; ov_wr = 0; dir_wr = 0; upd_i = 0; flag_clr_i = 0;
    check_model(tag);
  endtask

  task automatic cfg(logic [N_EVT-1:0] en, logic pe, logic a, logic cc, logic ie, logic lk);
    cfg_wr = 1; cfg_evt_en = en; cfg_prot_en = pe; cfg_act = a;
    cfg_cyc_mode = cc; cfg_irq_en = ie; cfg_lock = lk;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11 reset state
    check_val("R11", "ov_o", ov_o, 8'h00);
    check_val("R11", "dir_o", dir_o, 8'h00);
    check_val("R11", "flag", {7'd0, fault_flag_o}, 8'h00);
    check_val("R11", "irq", {7'd0, err_irq_o}, 8'h00);

    cfg(4'b0001, 1, 0, 0, 1, 0);
    ov_wr = 1; ov_wdata = 8'hA5; dir_wr = 1; dir_wdata = 8'h3C;
    step("R1");
    check_val("R1", "ov_o pass", ov_o, 8'hA5);
    // R1 masked channel ignored
    evt_i = 4'b0010; step("R1"); step("R1");
    check_val("R1", "ov_o masked", ov_o, 8'hA5);
    check_val("R1", "flag masked", {7'd0, fault_flag_o}, 8'h00);
    evt_i = 4'b0000; step("R1");
    // R2 / R4 latency
    evt_i = 4'b0001; step("R2");
    check_val("R2", "ov_o one edge", ov_o, 8'hA5);
    step("R2");
    check_val("R2", "ov_o cleared", ov_o, 8'h00);
    check_val("R2", "dir_o kept", dir_o, 8'h3C);
    check_val("R4", "flag", {7'd0, fault_flag_o}, 8'h01);
    check_val("R4", "irq", {7'd0, err_irq_o}, 8'h01);
    // R10 writes during fault
    ov_wr = 1; ov_wdata = 8'hFF; dir_wr = 1; dir_wdata = 8'h0F; step("R10");
    check_val("R10", "ov_o drop", ov_o, 8'h00);
    check_val("R10", "dir_o take", dir_o, 8'h0F);
    // R5 latched: condition gone, flag still set, UPDATE ignored
    dti_en = 4'b0101; pat_mode = 0;
    evt_i = 0; step("R5"); step("R5");
    upd_i = 1; step("R5");
    check_val("R5", "ov_o held", ov_o, 8'h00);
    // R8 clear racing a new event
    evt_i = 4'b0001; flag_clr_i = 1; step("R8");
    check_val("R8", "flag kept", {7'd0, fault_flag_o}, 8'h01);
    evt_i = 0; step("R8"); step("R8");
    flag_clr_i = 1; step("R8");
    check_val("R8", "flag cleared", {7'd0, fault_flag_o}, 8'h00);
    upd_i = 1; step("R7");
    check_val("R7", "ov_o pair restore", ov_o, 8'h33);
    check_val("R7", "dir_o untouched", dir_o, 8'h0F);
    // R6 / R3 cycle-by-cycle with direction clear and pattern
    cfg(4'b0001, 1, 1, 1, 0, 0); step("R6");
    pat_mode = 1; pat_buf = 8'h96;
    evt_i = 4'b0001; step("R3"); step("R3");
    check_val("R3", "dir_o cleared", dir_o, 8'h00);
    check_val("R3", "ov_o kept", ov_o, 8'h33);
    evt_i = 0; step("R6"); step("R6");
    upd_i = 1; step("R6");
    check_val("R6", "dir_o pattern", dir_o, 8'h96);
    check_val("R6", "flag still set", {7'd0, fault_flag_o}, 8'h01);
    flag_clr_i = 1; step("R8");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      evt_i      = ($urandom % 5 == 0) ? N_EVT'($urandom) : '0;
      upd_i      = ($urandom % 5 == 0);
      flag_clr_i = ($urandom % 4 == 0);
      ov_wr      = ($urandom % 6 == 0); ov_wdata  = OUT_W'($urandom);
      dir_wr     = ($urandom % 6 == 0); dir_wdata = OUT_W'($urandom);
      if ($urandom % 50 == 0) begin pat_mode = $urandom; pat_buf = OUT_W'($urandom); dti_en = PAIRS'($urandom); end
      if ($urandom % 40 == 0) cfg(N_EVT'($urandom), ($urandom % 4 != 0), $urandom, $urandom, $urandom, 0);
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 0; ov_wr = 0; dir_wr = 0; upd_i = 0; flag_clr_i = 0;
      check_model("R1/R2/R3/R4/R5/R6/R7/R8/R10");
    end

    // R9 lock
    evt_i = 0; repeat (3) begin upd_i = 1; flag_clr_i = 1; step("R9"); end
    cfg(4'b0001, 1, 0, 0, 0, 1); step("R9");
    ov_wr = 1; ov_wdata = 8'h5A; step("R9");
    cfg(4'b0000, 0, 1, 1, 1, 0); step("R9");
    evt_i = 4'b0001; step("R9"); step("R9");
    check_val("R9", "ov_o still guarded", ov_o, 8'h00);
    check_val("R9", "irq still off", {7'd0, err_irq_o}, 8'h00);
    evt_i = 0; step("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule